// File: doc/BRIEF.md
# Effective Address Evaluation Sequencer

This block is the front end of a 36-bit word-addressed processor. It fetches an instruction from a small on-block word memory, then resolves the instruction's effective address by applying index registers and following indirect words until a word without the indirect flag is reached. Each step rewrites the held instruction so that the address fields it consumed are cleared, leaving a plain resolved address. The block then hands the opcode, the accumulator number and the resolved 18-bit address to an execute stage and waits for that stage to finish.

The memory holds 32 words. Its lowest 16 words are the general registers, which serve both as accumulators and as index registers. The image is written through a load port, normally while reset is held. A single four-way address multiplexer picks the memory address from the program counter, from the low bits of the address being resolved, from the accumulator field or from the index field. The selector and the combinational read data are visible at the ports, so that the execute stage can read the selected accumulator.

Top module: `ea_sequencer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the program counter is octal 20, `addr_sel` selects the program counter and `exec_start` is low.
- R2: A fetch takes one clock: it reads the word at the low 5 bits of the program counter into the instruction register, and the program counter advances by exactly one per fetch, modulo 2^18, and holds at all other times.
- R3: Instruction fields, counted from bit 35 down: opcode bits 35..27, accumulator number bits 26..23, indirect flag bit 22, index field bits 21..18, address bits 17..0. `opcode` and `acc_num` report the fetched instruction's fields.
- R4: A nonzero index field adds the low 18 bits of that register to the address, modulo 2^18, in one clock, and clears the index field. An index field of zero means no indexing.
- R5: A set indirect flag reads the word at the low 5 bits of the current address (higher bits ignored) in one clock and takes that word's indirect flag, index field and address as the new ones; indexing of the new word is done before any further indirection, and evaluation repeats until the flag is clear.
- R6: `addr_sel` encodes the memory address source as 0 program counter, 1 address being resolved, 2 accumulator field, 3 index field; `mem_addr` follows that source and `mem_rdata` is the memory word at `mem_addr`.
- R7: `exec_start` is a one-cycle pulse on the first cycle the address is resolved; `ea`, `opcode` and `acc_num` stay stable until `exec_done` is seen, after which the next cycle is a fetch. `exec_done` outside that wait has no effect.
- R8: A write on the load port stores `load_data` at `load_addr`, and the stored word is what fetches, indexing and indirection read.
- R9: The number of cycles from the fetch cycle up to, not including, the `exec_start` cycle is one plus the number of index steps plus the number of indirect steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_we | input | 1 | Memory load write enable |
| load_addr | input | 5 | Memory load word address |
| load_data | input | 36 | Memory load word |
| addr_sel | output | 2 | Memory address source (0 PC, 1 address, 2 accumulator, 3 index) |
| mem_addr | output | 5 | Selected memory address |
| mem_rdata | output | 36 | Memory word at `mem_addr` |
| pc | output | 18 | Program counter |
| exec_start | output | 1 | Pulse: resolved instruction handed to execute |
| exec_done | input | 1 | Execute stage finished |
| ea | output | 18 | Resolved effective address |
| opcode | output | 9 | Instruction opcode |
| acc_num | output | 4 | Accumulator number |

## Verification
A directed image tries a plain instruction, index only, an index sum that wraps past 2^18, a single indirection that lands on an indexed word, a two-level indirection reached through an address with high bits set, and an index followed by indirection; together these separate the order of index and indirect steps, the modulo adder and the truncation to 5 memory address bits. Random images with sparse indirect flags and random index fields then run many instructions, including the program counter wrapping into the register words, each compared with an address and step count computed by a bench function. The cycle count to `exec_start` tells a correct one-clock-per-step sequencer from one that wastes or skips a cycle, and a held `exec_done` that spills into the following fetch shows whether a stray completion is ignored.

// File: rtl/ea_sequencer.sv
module ea_sequencer #(
  parameter int ADDR_W    = 18,
  parameter int MEM_WORDS = 32,
  parameter logic [ADDR_W-1:0] PC_RESET = 18'o20,
  localparam int MA_W   = $clog2(MEM_WORDS),
  localparam int IX_W   = 4,
  localparam int AC_W   = 4,
  localparam int OP_W   = 9,
  localparam int X_LO   = ADDR_W,
  localparam int I_BIT  = X_LO + IX_W,
  localparam int AC_LO  = I_BIT + 1,
  localparam int OP_LO  = AC_LO + AC_W,
  localparam int WORD_W = OP_LO + OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_we,
  input  logic [MA_W-1:0]   load_addr,
  input  logic [WORD_W-1:0] load_data,
  output logic [1:0]        addr_sel,
  output logic [MA_W-1:0]   mem_addr,
  output logic [WORD_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] pc,
  output logic              exec_start,
  input  logic              exec_done,
  output logic [ADDR_W-1:0] ea,
  output logic [OP_W-1:0]   opcode,
  output logic [AC_W-1:0]   acc_num
);

  localparam logic [1:0] SEL_PC = 2'd0;
  localparam logic [1:0] SEL_MA = 2'd1;
  localparam logic [1:0] SEL_AC = 2'd2;
  localparam logic [1:0] SEL_X  = 2'd3;

  typedef enum logic [1:0] {S_FETCH, S_EVAL, S_EXEC} state_t;

  state_t            state;
  logic [WORD_W-1:0] ir, ir_n;
  logic [WORD_W-1:0] mem [MEM_WORDS];
  logic              resolved;

  wire [IX_W-1:0]   ir_x   = ir[X_LO +: IX_W];
  wire              ir_i   = ir[I_BIT];
  wire [ADDR_W-1:0] ir_y   = ir[ADDR_W-1:0];
  wire [IX_W-1:0]   rd_x   = mem_rdata[X_LO +: IX_W];
  wire              rd_i   = mem_rdata[I_BIT];
  wire [ADDR_W-1:0] y_sum  = ir_y + mem_rdata[ADDR_W-1:0];

  assign ea      = ir_y;
  assign opcode  = ir[OP_LO +: OP_W];
  assign acc_num = ir[AC_LO +: AC_W];

  always_ff @(posedge clk)
    if (load_we) mem[load_addr] <= load_data;

  always_comb begin
    case (state)
      S_FETCH: addr_sel = SEL_PC;
      S_EVAL:  addr_sel = (ir_x != '0) ? SEL_X : SEL_MA;
      default: addr_sel = SEL_AC;
    endcase
  end

  always_comb begin
    case (addr_sel)
      SEL_PC:  mem_addr = pc[MA_W-1:0];
      SEL_MA:  mem_addr = ir_y[MA_W-1:0];
      SEL_AC:  mem_addr = MA_W'(acc_num);
      default: mem_addr = MA_W'(ir_x);
    endcase
  end

  assign mem_rdata = mem[mem_addr];

  always_comb begin
    ir_n     = ir;
    resolved = 1'b0;
    if (state == S_FETCH) begin
      ir_n     = mem_rdata;
      resolved = (rd_x == '0) && !rd_i;
    end else if (ir_x != '0) begin
      ir_n[ADDR_W-1:0]      = y_sum;
      ir_n[X_LO +: IX_W]    = '0;
      resolved              = !ir_i;
    end else begin
      ir_n[I_BIT:0] = mem_rdata[I_BIT:0];
      resolved      = (rd_x == '0) && !rd_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_FETCH;
      pc         <= PC_RESET;
      ir         <= '0;
      exec_start <= 1'b0;
    end else begin
      exec_start <= 1'b0;
      case (state)
        S_FETCH: begin
          ir         <= ir_n;
          pc         <= pc + 1'b1;
          state      <= resolved ? S_EXEC : S_EVAL;
          exec_start <= resolved;
        end
        S_EVAL: begin
          ir <= ir_n;
          if (resolved) begin
            state      <= S_EXEC;
            exec_start <= 1'b1;
          end
        end
        default: if (exec_done) state <= S_FETCH;
      endcase
    end
  end

  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_FETCH |=> pc == $past(pc) + 1'b1);

  p_pc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state != S_FETCH |=> $stable(pc));

  p_index_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EVAL && ir_x != '0) |=> ir[X_LO +: IX_W] == '0);

  p_start_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |=> !exec_start);

  p_start_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |-> addr_sel == SEL_AC);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EXEC && !exec_done) |=> ($stable(ea) && $stable(opcode) && $stable(acc_num)));

  p_resolved_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |-> (!ir_i && ir_x == '0));

endmodule

// File: tb/ea_sequencer_test.sv
module ea_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_we = 1'b0;
  logic [4:0]  load_addr = '0;
  logic [35:0] load_data = '0;
  logic [1:0]  addr_sel;
  logic [4:0]  mem_addr;
  logic [35:0] mem_rdata;
  logic [17:0] pc;
  logic        exec_start;
  logic        exec_done = 1'b0;
  logic [17:0] ea;
  logic [8:0]  opcode;
  logic [3:0]  acc_num;

  always #10 clk = ~clk;

  ea_sequencer uut (
    .clk(clk), .rst_n(rst_n), .load_we(load_we), .load_addr(load_addr),
    .load_data(load_data), .addr_sel(addr_sel), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .pc(pc), .exec_start(exec_start),
    .exec_done(exec_done), .ea(ea), .opcode(opcode), .acc_num(acc_num)
  );

  logic [35:0] img [32];
  logic [17:0] pcm;
  int total = 0;
  int bad = 0;
  int cycles = 0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      $display("FAIL watchdog: act=%0d cycles exp=<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] mk(input int op, input int ac, input int ind,
                                     input int ix, input logic [17:0] y);
    return {9'(op), 4'(ac), 1'(ind), 4'(ix), y};
  endfunction

  function automatic int resolve(input logic [35:0] w, output logic [17:0] ea_o);
    int steps = 0;
    logic i = w[22];
    logic [3:0] x = w[21:18];
    logic [17:0] y = w[17:0];
    logic [35:0] t;
    for (int k = 0; k < 80; k++) begin
      if (x != 0) begin
        y = y + img[x][17:0];
        x = 0;
        steps++;
      end
      if (!i) begin
        ea_o = y;
        return steps;
      end
      t = img[y[4:0]];
      i = t[22];
      x = t[21:18];
      y = t[17:0];
      steps++;
    end
    ea_o = y;
    return -1;
  endfunction

  task automatic load_and_start();
    rst_n = 1'b0;
    exec_done = 1'b0;
    for (int a = 0; a < 32; a++) begin
      @(negedge clk);
      load_we = 1'b1;
      load_addr = 5'(a);
      load_data = img[a];
    end
    @(negedge clk);
    load_we = 1'b0;
    @(negedge clk);
    chk("R1 reset pc", 64'(pc), 64'(18'o20));
    chk("R1 reset sel", 64'(addr_sel), 64'd0);
    chk("R1 reset start", 64'(exec_start), 64'd0);
    chk("R8 loaded word visible", 64'(mem_rdata), 64'(img[16]));
    rst_n = 1'b1;
    pcm = 18'o20;
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) begin
      logic [35:0] w;
      logic [17:0] eexp;
      int steps;
      int cnt;
      int to;
      int d;
      int stray;
      w = img[pcm[4:0]];
      steps = resolve(w, eexp);
      cnt = 0;
      to = 0;
      chk("R6 fetch sel", 64'(addr_sel), 64'd0);
      chk("R6 fetch addr", 64'(mem_addr), 64'(pcm[4:0]));
      while (!exec_start && to < 300) begin
        if (addr_sel != 2'd2) cnt++;
        @(negedge clk);
        exec_done = 1'b0;
        to++;
      end
      exec_done = 1'b0;
      if (to >= 300) begin
        chk("R7 start seen", 64'd0, 64'd1);
        return;
      end
      chk("R4 R5 ea", 64'(ea), 64'(eexp));
      chk("R3 opcode", 64'(opcode), 64'(w[35:27]));
      chk("R3 acc", 64'(acc_num), 64'(w[26:23]));
      chk("R9 cycles", 64'(cnt), 64'(1 + steps));
      chk("R2 pc", 64'(pc), 64'(pcm + 18'd1));
      chk("R6 ac sel", 64'(addr_sel), 64'd2);
      chk("R6 ac data", 64'(mem_rdata), 64'(img[w[26:23]]));
      d = $urandom_range(0, 3);
      for (int j = 0; j < d; j++) begin
        @(negedge clk);
        chk("R7 single pulse", 64'(exec_start), 64'd0);
        chk("R7 ea held", 64'(ea), 64'(eexp));
      end
      exec_done = 1'b1;
      stray = $urandom_range(0, 1);
      @(negedge clk);
      if (stray == 0) exec_done = 1'b0;
      pcm = pcm + 18'd1;
    end
  endtask

  initial begin
    logic [17:0] tmp;
    void'($urandom(32'd5150));
    for (int a = 0; a < 32; a++) img[a] = mk(a * 3, a & 15, 0, 0, 18'(a * 7));
    img[1]  = mk(0, 0, 0, 0, 18'd5);
    img[2]  = mk(0, 0, 0, 0, 18'h3FFFF);
    img[3]  = mk(0, 0, 0, 1, 18'd7);
    img[4]  = mk(0, 0, 1, 0, 18'd3);
    img[16] = mk(9'o400, 3, 0, 0, 18'o123);
    img[17] = mk(9'o404, 5, 0, 1, 18'd10);
    img[18] = mk(9'o410, 1, 0, 2, 18'd2);
    img[19] = mk(9'o414, 2, 1, 0, 18'd3);
    img[20] = mk(9'o420, 6, 1, 0, 18'o40 | 18'd4);
    img[21] = mk(9'o424, 7, 1, 1, 18'h3FFFE);
    load_and_start();
    run(40);

    for (int t = 0; t < 10; t++) begin
      int ok;
      do begin
        ok = 1;
        for (int a = 0; a < 32; a++) begin
          logic [35:0] w;
          w = {4'($urandom), $urandom};
          w[22] = ($urandom_range(0, 3) == 0);
          if ($urandom_range(0, 1) == 0) w[21:18] = 4'd0;
          img[a] = w;
        end
        for (int a = 0; a < 32; a++)
          if (resolve(img[a], tmp) < 0) ok = 0;
      end while (ok == 0);
      load_and_start();
      run(60);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule